// File: doc/BRIEF.md
# Interlocked Bus Read Link

This block models both parties of a clockless, fully interlocked read over one shared line set that carries first an address and then data. A requester takes a read address from a start/done interface, places the address on the shared lines and raises a read request. A memory-side responder latches that address, acknowledges it, performs an internal access and then returns the word with a data-ready strobe. The requester acknowledges that strobe, and the transaction closes.

No step has a fixed delay. Each party moves only after it has seen the other party's previous edge. Each party sees the other's lines through its own two-flop synchronizer. The read thus consists of two four-event handshakes in strict order: one for the address and one for the data. Between the phases and when idle, neither party drives the shared lines and they float. The observation ports expose the handshake lines, the resolved value on the shared lines and which party drives them.

The responder's memory is a read-only array. Its contents are set at reset from a fixed formula, so every returned word can be predicted.

Top module: `asyncReadLink`

## Requirements
- R1: While `rstN` is low, and after its release until a start is accepted, `readReq`, `respAck`, `dataRdy`, `reqAck` and `done` are low, `busOwner` is 2'b00 (floating), and `busValue` and `rdData` are zero.
- R2: When the requester is idle and `start` is high at a rising edge, it latches `reqAddr`, drives that address zero-extended onto the shared lines (`busOwner` = 2'b01) and raises `readReq`. It holds both until it has seen `respAck` high.
- R3: When the responder sees `readReq` high, it captures the address from the shared lines and raises `respAck`. It keeps `respAck` high until it has seen `readReq` low, and then lowers it.
- R4: When the requester sees `respAck` high, it stops driving the shared lines and lowers `readReq` in the same cycle, which leaves `busOwner` at 2'b00.
- R5: After lowering `respAck`, the responder waits `ACCESS_DELAY` cycles. It then drives the addressed word (`busOwner` = 2'b10) and raises `dataRdy`, and it holds both until it has seen `reqAck` high. It then releases the lines and lowers `dataRdy`.
- R6: When the requester sees `dataRdy` high, it captures the shared lines and raises `reqAck`. When it sees `dataRdy` low, it lowers `reqAck` and ends the transaction.
- R7: In every transaction, the four handshake lines change in exactly this order and in no other way: `readReq` rises, `respAck` rises, `readReq` falls, `respAck` falls, `dataRdy` rises, `reqAck` rises, `dataRdy` falls, `reqAck` falls.
- R8: The word returned for address a is (37*a + 90) mod 2^DATA_W.
- R9: `done` is high for exactly one cycle, 18 + `ACCESS_DELAY` cycles after the edge that accepted `start`. `rdData` takes the returned word in that same cycle and changes at no other time.
- R10: `start` is ignored while a transaction is in progress: no further `readReq` rise occurs and the returned word belongs to the accepted address.
- R11: At most one party drives the shared lines at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both parties and their synchronizers |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a read of `reqAddr` |
| reqAddr | input | ADDR_W | Address to read |
| done | output | 1 | One-cycle pulse when a read completes |
| rdData | output | DATA_W | Last word read, held until the next completion |
| readReq | output | 1 | Requester's read request line |
| respAck | output | 1 | Responder's address acknowledge line |
| dataRdy | output | 1 | Responder's data-valid line |
| reqAck | output | 1 | Requester's data acknowledge line |
| busValue | output | DATA_W | Resolved value of the shared lines, zero when floating |
| busOwner | output | 2 | Bit 0: requester drives; bit 1: responder drives |

## Verification
Two functions can fall in the same cycle. The responder may still be tearing down the previous data handshake (`dataRdy` low, waiting for `reqAck` to fall through its synchronizer) when the requester accepts a new start and raises `readReq` for the next address. The bench provokes this overlap by holding `start` high across consecutive reads, so that each new read is accepted on the edge right after `done`. It judges the result by the per-transaction event order, the single-driver rule, and the returned word for each address. A second overlap is a start pulse that arrives mid-transaction with a different address. This is judged by the count of `readReq` rises and the word that is returned.

// File: rtl/asyncReadLinkPkg.sv
package asyncReadLinkPkg;

  typedef enum logic [2:0] {
    RQ_IDLE, RQ_ADDR, RQ_REL, RQ_WDATA, RQ_ACKD
  } rqState_t;

  typedef enum logic [2:0] {
    RS_IDLE, RS_ACK, RS_ACCESS, RS_DRIVE, RS_DROP
  } rsState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic reqLoadAddr;  // latch the start address
    logic reqDrive;     // requester owns the shared lines
    logic reqCapture;   // requester samples returned data
    logic reqPublish;   // copy captured word to rdData
    logic respCapture;  // responder samples the address
    logic respDrive;    // responder owns the shared lines
  } strobes_t;

endpackage

// File: rtl/syncChain.sv
module syncChain #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/asyncReadLinkCtrl.sv
module asyncReadLinkCtrl
  import asyncReadLinkPkg::*;
#(
  parameter int ACCESS_DELAY = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output strobes_t stb,
  output logic     readReq,
  output logic     respAck,
  output logic     dataRdy,
  output logic     reqAck,
  output logic     done
);
  localparam int CNT_W = $clog2(ACCESS_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACCESS_DELAY - 1);

  rqState_t rqState;
  rsState_t rsState;
  logic [CNT_W-1:0] accessCnt;

  // each party sees the other's lines only through a synchronizer
  logic [1:0] rqSeen;  // {dataRdy, respAck} as seen by the requester
  logic [1:0] rsSeen;  // {reqAck, readReq} as seen by the responder
  logic ackSeen, rdySeen, reqSeen, rAckSeen;

  syncChain #(.WIDTH(2), .STAGES(2)) rqSync_i (
    .clk(clk), .rstN(rstN), .asyncIn({dataRdy, respAck}), .syncOut(rqSeen)
  );
  syncChain #(.WIDTH(2), .STAGES(2)) rsSync_i (
    .clk(clk), .rstN(rstN), .asyncIn({reqAck, readReq}), .syncOut(rsSeen)
  );

  assign ackSeen  = rqSeen[0];
  assign rdySeen  = rqSeen[1];
  assign reqSeen  = rsSeen[0];
  assign rAckSeen = rsSeen[1];

  // requester
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rqState <= RQ_IDLE;
    end else begin
      unique case (rqState)
        RQ_IDLE:  if (start)    rqState <= RQ_ADDR;
        RQ_ADDR:  if (ackSeen)  rqState <= RQ_REL;
        RQ_REL:   if (!ackSeen) rqState <= RQ_WDATA;
        RQ_WDATA: if (rdySeen)  rqState <= RQ_ACKD;
        RQ_ACKD:  if (!rdySeen) rqState <= RQ_IDLE;
        default:                rqState <= RQ_IDLE;
      endcase
    end
  end

  // responder
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rsState   <= RS_IDLE;
      accessCnt <= '0;
    end else begin
      unique case (rsState)
        RS_IDLE: if (reqSeen) rsState <= RS_ACK;
        RS_ACK: if (!reqSeen) begin
          rsState   <= RS_ACCESS;
          accessCnt <= '0;
        end
        RS_ACCESS: begin
          if (accessCnt == CNT_LAST) rsState <= RS_DRIVE;
          else accessCnt <= accessCnt + 1'b1;
        end
        RS_DRIVE: if (rAckSeen)  rsState <= RS_DROP;
        RS_DROP:  if (!rAckSeen) rsState <= RS_IDLE;
        default:                 rsState <= RS_IDLE;
      endcase
    end
  end

  assign readReq = (rqState == RQ_ADDR);
  assign reqAck  = (rqState == RQ_ACKD);
  assign respAck = (rsState == RS_ACK);
  assign dataRdy = (rsState == RS_DRIVE);

  always_comb begin
    stb.reqLoadAddr = (rqState == RQ_IDLE) && start;
    stb.reqDrive    = (rqState == RQ_ADDR);
    stb.reqCapture  = (rqState == RQ_WDATA) && rdySeen;
    stb.reqPublish  = (rqState == RQ_ACKD) && !rdySeen;
    stb.respCapture = (rsState == RS_IDLE) && reqSeen;
    stb.respDrive   = (rsState == RS_DRIVE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) done <= 1'b0;
    else       done <= stb.reqPublish;
  end
endmodule

// File: rtl/asyncReadLinkData.sv
module asyncReadLinkData
  import asyncReadLinkPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] busValue,
  output logic [1:0]        busOwner
);
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [DATA_W-1:0] memWord(input int a);
    logic [31:0] w;
    w = 32'(a) * 32'd37 + 32'd90;
    return w[DATA_W-1:0];
  endfunction

  logic [ADDR_W-1:0] rqAddr;
  logic [ADDR_W-1:0] rsAddr;
  logic [DATA_W-1:0] rqCapture;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= memWord(i);
    end
  end

  // shared lines: enable-controlled drivers resolved here, zero when floating
  always_comb begin
    busOwner = {stb.respDrive, stb.reqDrive};
    if (stb.reqDrive)       busValue = DATA_W'(rqAddr);
    else if (stb.respDrive) busValue = mem[rsAddr];
    else                    busValue = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rqAddr    <= '0;
      rsAddr    <= '0;
      rqCapture <= '0;
      rdData    <= '0;
    end else begin
      if (stb.reqLoadAddr) rqAddr    <= reqAddr;
      if (stb.respCapture) rsAddr    <= busValue[ADDR_W-1:0];
      if (stb.reqCapture)  rqCapture <= busValue;
      if (stb.reqPublish)  rdData    <= rqCapture;
    end
  end
endmodule

// File: rtl/asyncReadLink.sv
module asyncReadLink
  import asyncReadLinkPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int ACCESS_DELAY = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              readReq,
  output logic              respAck,
  output logic              dataRdy,
  output logic              reqAck,
  output logic [DATA_W-1:0] busValue,
  output logic [1:0]        busOwner
);
  strobes_t stb;

  asyncReadLinkCtrl #(.ACCESS_DELAY(ACCESS_DELAY)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .stb(stb),
    .readReq(readReq), .respAck(respAck), .dataRdy(dataRdy),
    .reqAck(reqAck), .done(done)
  );

  asyncReadLinkData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) data_i (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr),
    .rdData(rdData), .busValue(busValue), .busOwner(busOwner)
  );
endmodule

// File: rtl/asyncReadLinkChecker.sv
module asyncReadLinkChecker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              done,
  input logic [DATA_W-1:0] rdData,
  input logic              readReq,
  input logic              respAck,
  input logic              dataRdy,
  input logic              reqAck,
  input logic [DATA_W-1:0] busValue,
  input logic [1:0]        busOwner
);
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rstN)
    $countones(busOwner) <= 1); // R11
  AST_REQ_OWNS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    readReq |-> busOwner == 2'b01); // R2
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (readReq && !respAck) |=> readReq); // R2
  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(respAck) |-> readReq); // R3
  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (respAck && readReq) |=> respAck); // R3
  AST_RDY_OWNS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    dataRdy |-> busOwner == 2'b10); // R5
  AST_RDY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (dataRdy && !reqAck) |=> dataRdy); // R5
  AST_RACK_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqAck) |-> dataRdy); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(rdData)); // R9
endmodule

bind asyncReadLink asyncReadLinkChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/asyncReadLink_tb_top.sv
module asyncReadLink_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int ACCESS_DELAY = 4;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic done, readReq, respAck, dataRdy, reqAck;
  logic [DATA_W-1:0] rdData, busValue;
  logic [1:0] busOwner;

  int checks = 0;
  int fails = 0;
  int reqRises = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asyncReadLink #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACCESS_DELAY(ACCESS_DELAY)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .reqAddr(reqAddr), .done(done),
    .rdData(rdData), .readReq(readReq), .respAck(respAck), .dataRdy(dataRdy),
    .reqAck(reqAck), .busValue(busValue), .busOwner(busOwner)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expWord(input int a);
    return (37 * a + 90) % (1 << DATA_W);
  endfunction

  // event-order monitor: R7, plus R11 and done width R9
  int ph = 0;
  logic [3:0] prevLines = '0;
  logic prevDone = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      logic [3:0] cur;
      cur = {reqAck, dataRdy, respAck, readReq};
      if (cur[0] && !prevLines[0]) reqRises++;
      for (int s = 0; s < 4; s++) begin
        if (cur[s] != prevLines[s]) begin
          int expId;
          bit expVal;
          expId  = (ph < 4) ? (ph % 2) : 2 + (ph % 2);
          expVal = (ph == 0 || ph == 1 || ph == 4 || ph == 5);
          check(s == expId && cur[s] == expVal, "R7 order", s * 2 + int'(cur[s]),
                expId * 2 + int'(expVal));
          ph = (ph + 1) % 8;
        end
      end
      check(busOwner != 2'b11, "R11 single driver", int'(busOwner), 0);
      if (prevDone) check(!done, "R9 done width", int'(done), 0);
      prevLines = cur;
      prevDone  = done;
    end
  end

  // one read; returns cycles from accepting edge to done
  task automatic doRead(input int a, output int lat);
    @(negedge clk);
    reqAddr = ADDR_W'(a);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(readReq && busOwner == 2'b01 && busValue == DATA_W'(a), "R2 address phase",
          int'(busValue), a);
    lat = 0;
    while (!done && lat < 1000) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    check(!readReq && !respAck && !dataRdy && !reqAck && !done, "R1 lines in reset",
          int'({readReq, respAck, dataRdy, reqAck, done}), 0);
    check(busOwner == 2'b00 && busValue == '0 && rdData == '0, "R1 bus in reset",
          int'(busOwner), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(!readReq && busOwner == 2'b00 && !done, "R1 idle after reset", int'(busOwner), 0);

    // sweep every address: data R8, latency R9, handshake phases R3 R4 R5 R6
    for (int a = 0; a < DEPTH; a++) begin
      doRead(a, lat);
      check(done, "R6 transaction completes", int'(done), 1);
      check(rdData == DATA_W'(expWord(a)), "R8 returned word", int'(rdData), expWord(a));
      check(lat == 18 + ACCESS_DELAY, "R9 latency", lat, 18 + ACCESS_DELAY);
      check(busOwner == 2'b00, "R4 R5 bus floats after read", int'(busOwner), 0);
      @(negedge clk);
      check(rdData == DATA_W'(expWord(a)), "R9 data held", int'(rdData), expWord(a));
    end

    // R3 R4: watch the address handshake step by step
    @(negedge clk);
    reqAddr = 4'd9;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!respAck) @(negedge clk);
    check(readReq && busOwner == 2'b01, "R3 ack while request high", int'(busOwner), 1);
    while (readReq) @(negedge clk);
    check(busOwner == 2'b00 && respAck, "R4 release with ack still high", int'(busOwner), 0);
    while (!dataRdy) @(negedge clk);
    check(busOwner == 2'b10 && busValue == DATA_W'(expWord(9)), "R5 data phase",
          int'(busValue), expWord(9));
    while (!done) @(negedge clk);
    check(rdData == DATA_W'(expWord(9)), "R6 data captured", int'(rdData), expWord(9));

    // R10: start mid-transaction with another address is ignored
    repeat (5) @(negedge clk);
    reqRises = 0;
    reqAddr = 4'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    reqAddr = 4'd12;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check(rdData == DATA_W'(expWord(3)), "R10 word of accepted address", int'(rdData), expWord(3));
    repeat (40) @(negedge clk);
    check(reqRises == 1, "R10 single request", reqRises, 1);

    // back-to-back: start held, next read accepted right after done
    reqAddr = 4'd15;
    start = 1'b1;
    for (int k = 0; k < 4; k++) begin
      int a;
      a = (15 + 5 * k) % DEPTH;
      @(negedge clk);
      while (!done) @(negedge clk);
      check(rdData == DATA_W'(expWord(a)), "R8 back-to-back word", int'(rdData), expWord(a));
      reqAddr = ADDR_W'((15 + 5 * (k + 1)) % DEPTH);
    end
    start = 1'b0;
    repeat (40) @(negedge clk);
    check(ph == 0 && !readReq && busOwner == 2'b00, "R7 all handshakes closed", ph, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule